// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Flag Register

This block is the execution core of a small accumulator machine. It holds the 8-bit accumulator and a 4-bit flag register. Each accepted operation takes the accumulator as one operand. The other operand arrives on a byte-wide bus, which carries whatever an immediate, a register or a memory location supplied. Arithmetic and logic results go back into the accumulator. Compare reports only through the flags, and moves load the accumulator without touching any flag.

Beside the byte path sits a 16-bit path for register pairs. It increments or decrements one pair, or adds two pairs, and returns the new pair value on its own output. The same path serves byte increment and decrement of a register or memory operand: that result comes back on a separate byte output, and the accumulator is left alone. Fetch, decode and the register file live outside this block.

Operations enter through a valid/ready handshake. The block never applies back-pressure: `in_ready` is high whenever reset is released, so every cycle with `in_valid` high is an accepted operation. Results are registered on the rising edge that accepts the operation and stay unchanged until a later operation writes them. `out_valid` is high for the one cycle after each acceptance. The output side has no ready signal, because the results are plain registers that hold their value.

Top module: `acc_alu`

## Requirements
- R1: During and directly after reset `acc_o`, `flags_o`, `byte_o`, `pair_o` and `out_valid` are all zero. `flags_o` bit 3 is sign, bit 2 zero, bit 1 even parity (1 when the result has an even count of ones) and bit 0 carry.
- R2: Op 1 (add) writes A+operand mod 256 to the accumulator. Carry is set to the carry out of bit 7, and sign, zero and parity describe the result.
- R3: Op 2 (subtract) writes A-operand mod 256 to the accumulator. It is formed as A plus the two's complement of the operand. Carry is 1 exactly when the operand exceeds A (borrow), and sign, zero and parity describe the result.
- R4: Op 3 (compare) sets all four flags exactly as op 2 would and leaves the accumulator unchanged.
- R5: Ops 4, 5 and 6 (AND, OR, XOR) write the bitwise result to the accumulator. They clear carry and set sign, zero and parity from the result.
- R6: Op 0 (move) loads the operand into the accumulator and leaves every flag bit as it was.
- R7: Ops 7 and 8 (byte increment and decrement) put operand+1 or operand-1, mod 256, on `byte_o`. They set sign, zero and parity from that value, keep carry, and leave the accumulator unchanged.
- R8: Ops 9 and 10 (pair increment and decrement) put `in_pair_a`+1 or `in_pair_a`-1, mod 65536, on `pair_o` and change no flag.
- R9: Op 11 (pair add) puts `in_pair_a`+`in_pair_b` mod 65536 on `pair_o`. It sets carry to the carry out of bit 15 and keeps sign, zero and parity.
- R10: Results appear on the rising edge that accepts an operation, and `out_valid` is high for the following cycle only. A cycle without `in_valid` changes no result register and no flag.
- R11: Op codes 12 to 15 are accepted and raise `out_valid`, but change no result and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_ready | output | 1 | High whenever out of reset; operation accepted when both are high |
| in_op | input | 4 | Operation select |
| in_opnd | input | 8 | Byte operand (immediate, register or memory data) |
| in_pair_a | input | 16 | First register pair |
| in_pair_b | input | 16 | Second register pair, used by pair add |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 4 | Sign, zero, parity, carry |
| byte_o | output | 8 | Byte increment/decrement result |
| pair_o | output | 16 | Register pair result |
| out_valid | output | 1 | One-cycle pulse after each accepted operation |

## Verification
The assertions assume that `in_op` and the operand buses are known whenever `in_valid` is high. They also assume that `rst_n` is held low across at least one rising edge before any operation arrives. The bench drives every input on the falling edge and keeps all buses at defined values from time zero. It raises `in_valid` for exactly one cycle per operation, samples on the next falling edge, and releases reset only after two full clock cycles.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_MOV  = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_CMP  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_INC8 = 4'd7,
    OP_DEC8 = 4'd8,
    OP_PINC = 4'd9,
    OP_PDEC = 4'd10,
    OP_PADD = 4'd11
  } alu_op_e;

  typedef struct packed {
    logic sgn;
    logic zro;
    logic par;
    logic cry;
  } alu_flags_t;
endpackage

// File: rtl/acc_alu_byte.sv
module acc_alu_byte
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_flags_t   flags_in,
  output logic [W-1:0] res,
  output alu_flags_t   flags_next,
  output logic         wr_acc,
  output logic         wr_byte,
  output logic         wr_flags
);
  logic [W:0] wide;
  logic       cry;

  always_comb begin
    wide     = '0;
    res      = '0;
    cry      = flags_in.cry;
    wr_acc   = 1'b0;
    wr_byte  = 1'b0;
    wr_flags = 1'b0;
    case (op)
      OP_MOV: begin
        res    = b;
        wr_acc = 1'b1;
      end
      OP_ADD: begin
        wide     = {1'b0, a} + {1'b0, b};
        res      = wide[W-1:0];
        cry      = wide[W];
        wr_acc   = 1'b1;
        wr_flags = 1'b1;
      end
      OP_SUB, OP_CMP: begin
        wide     = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
        res      = wide[W-1:0];
        cry      = ~wide[W];
        wr_acc   = (op == OP_SUB);
        wr_flags = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        if (op == OP_AND)     res = a & b;
        else if (op == OP_OR) res = a | b;
        else                  res = a ^ b;
        cry      = 1'b0;
        wr_acc   = 1'b1;
        wr_flags = 1'b1;
      end
      OP_INC8, OP_DEC8: begin
        res      = (op == OP_INC8) ? b + W'(1) : b - W'(1);
        wr_byte  = 1'b1;
        wr_flags = 1'b1;
      end
      default: ;
    endcase
    flags_next.sgn = res[W-1];
    flags_next.zro = (res == '0);
    flags_next.par = ~^res;
    flags_next.cry = cry;
  end
endmodule

// File: rtl/acc_alu_pair.sv
module acc_alu_pair
  import acc_alu_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic [3:0]    op,
  input  logic [PW-1:0] pa,
  input  logic [PW-1:0] pb,
  output logic [PW-1:0] pres,
  output logic          wr_pair,
  output logic          wr_cry,
  output logic          cry_out
);
  logic [PW:0] wide;

  always_comb begin
    wide    = '0;
    pres    = '0;
    wr_pair = 1'b0;
    wr_cry  = 1'b0;
    cry_out = 1'b0;
    case (op)
      OP_PINC: begin
        pres    = pa + PW'(1);
        wr_pair = 1'b1;
      end
      OP_PDEC: begin
        pres    = pa - PW'(1);
        wr_pair = 1'b1;
      end
      OP_PADD: begin
        wide    = {1'b0, pa} + {1'b0, pb};
        pres    = wide[PW-1:0];
        cry_out = wide[PW];
        wr_pair = 1'b1;
        wr_cry  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [W-1:0]      in_opnd,
  input  logic [2*W-1:0]    in_pair_a,
  input  logic [2*W-1:0]    in_pair_b,
  output logic [W-1:0]      acc_o,
  output logic [3:0]        flags_o,
  output logic [W-1:0]      byte_o,
  output logic [2*W-1:0]    pair_o,
  output logic              out_valid
);
  localparam int PW = 2 * W;

  logic [W-1:0]  acc_q, byte_q, b_res;
  logic [PW-1:0] pair_q, p_res;
  alu_flags_t    flags_q, b_flags;
  logic          b_wr_acc, b_wr_byte, b_wr_flags;
  logic          p_wr_pair, p_wr_cry, p_cry;
  logic          take;

  assign in_ready = rst_n;
  assign take     = in_valid & in_ready;

  acc_alu_byte #(.W(W)) u_byte (
    .op(in_op), .a(acc_q), .b(in_opnd), .flags_in(flags_q),
    .res(b_res), .flags_next(b_flags),
    .wr_acc(b_wr_acc), .wr_byte(b_wr_byte), .wr_flags(b_wr_flags)
  );

  acc_alu_pair #(.PW(PW)) u_pair (
    .op(in_op), .pa(in_pair_a), .pb(in_pair_b),
    .pres(p_res), .wr_pair(p_wr_pair), .wr_cry(p_wr_cry), .cry_out(p_cry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      byte_q    <= '0;
      pair_q    <= '0;
      flags_q   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= take;
      if (take) begin
        if (b_wr_acc)   acc_q   <= b_res;
        if (b_wr_byte)  byte_q  <= b_res;
        if (b_wr_flags) flags_q <= b_flags;
        if (p_wr_pair)  pair_q  <= p_res;
        if (p_wr_cry)   flags_q.cry <= p_cry;
      end
    end
  end

  assign acc_o   = acc_q;
  assign byte_o  = byte_q;
  assign pair_o  = pair_q;
  assign flags_o = flags_q;

  // R6: moves never disturb the flags
  a_r6_move_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_MOV) |=> $stable(flags_o));

  // R4: compare leaves the accumulator alone
  a_r4_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_CMP) |=> $stable(acc_o));

  // R5: logic operations clear carry
  a_r5_logic_clears_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_op == OP_AND || in_op == OP_OR || in_op == OP_XOR)) |=> !flags_o[0]);

  // R8: pair step leaves flags alone
  a_r8_pair_step_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_op == OP_PINC || in_op == OP_PDEC)) |=> $stable(flags_o));

  // R9: pair add touches only carry among the flags
  a_r9_padd_only_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_PADD) |=> $stable(flags_o[3:1]));

  // R10: idle cycles hold every result
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(acc_o) && $stable(flags_o) && $stable(pair_o) && $stable(byte_o) && !out_valid));

  // R7: byte step leaves accumulator and carry alone
  a_r7_byte_step_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_op == OP_INC8 || in_op == OP_DEC8)) |=> ($stable(acc_o) && $stable(flags_o[0])));
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [7:0]  in_opnd = '0;
  logic [15:0] in_pair_a = '0, in_pair_b = '0;
  logic [7:0]  acc_o, byte_o;
  logic [3:0]  flags_o;
  logic [15:0] pair_o;
  logic        out_valid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0]  e_acc = '0, e_byte = '0;
  logic [3:0]  e_flags = '0;
  logic [15:0] e_pair = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_opnd(in_opnd), .in_pair_a(in_pair_a), .in_pair_b(in_pair_b),
    .acc_o(acc_o), .flags_o(flags_o), .byte_o(byte_o), .pair_o(pair_o),
    .out_valid(out_valid)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] zsp(input logic [7:0] r, input logic c);
    return {r[7], (r == 8'h00), ~^r, c};
  endfunction

  task automatic check_all(input string req);
    chk(req, "acc", {8'h00, acc_o}, {8'h00, e_acc});
    chk(req, "flags", {12'h000, flags_o}, {12'h000, e_flags});
    chk(req, "byte", {8'h00, byte_o}, {8'h00, e_byte});
    chk(req, "pair", pair_o, e_pair);
  endtask

  task automatic issue(input string req, input logic [3:0] op, input logic [7:0] d,
                       input logic [15:0] pa, input logic [15:0] pb);
    logic [8:0]  w;
    logic [16:0] w16;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_opnd = d; in_pair_a = pa; in_pair_b = pb;
    @(negedge clk);
    in_valid = 1'b0;
    case (op)
      4'd0: e_acc = d;
      4'd1: begin w = e_acc + d; e_acc = w[7:0]; e_flags = zsp(w[7:0], w[8]); end
      4'd2, 4'd3: begin
        w = {1'b0, e_acc} - {1'b0, d};
        e_flags = zsp(w[7:0], d > e_acc);
        if (op == 4'd2) e_acc = w[7:0];
      end
      4'd4: begin e_acc = e_acc & d; e_flags = zsp(e_acc, 1'b0); end
      4'd5: begin e_acc = e_acc | d; e_flags = zsp(e_acc, 1'b0); end
      4'd6: begin e_acc = e_acc ^ d; e_flags = zsp(e_acc, 1'b0); end
      4'd7: begin e_byte = d + 8'd1; e_flags = zsp(e_byte, e_flags[0]); end
      4'd8: begin e_byte = d - 8'd1; e_flags = zsp(e_byte, e_flags[0]); end
      4'd9: e_pair = pa + 16'd1;
      4'd10: e_pair = pa - 16'd1;
      4'd11: begin w16 = pa + pb; e_pair = w16[15:0]; e_flags[0] = w16[16]; end
      default: ;
    endcase
    chk("R10", "out_valid", {15'h0, out_valid}, 16'h0001);
    check_all(req);
  endtask

  task automatic t_reset();
    chk("R1", "out_valid", {15'h0, out_valid}, 16'h0000);
    check_all("R1");
  endtask

  task automatic t_move();
    issue("R6", 4'd0, 8'h5A, 16'h0, 16'h0);
    issue("R2", 4'd1, 8'hC0, 16'h0, 16'h0);   // 5A+C0 = 1A, carry
    issue("R6", 4'd0, 8'h00, 16'h0, 16'h0);   // flags must survive
  endtask

  task automatic t_add();
    issue("R6", 4'd0, 8'h80, 16'h0, 16'h0);
    issue("R2", 4'd1, 8'h80, 16'h0, 16'h0);   // zero with carry
    issue("R2", 4'd1, 8'h7F, 16'h0, 16'h0);   // no carry, positive
    issue("R2", 4'd1, 8'h01, 16'h0, 16'h0);   // 80, sign
  endtask

  task automatic t_sub_cmp();
    issue("R6", 4'd0, 8'h10, 16'h0, 16'h0);
    issue("R3", 4'd2, 8'h20, 16'h0, 16'h0);   // borrow
    issue("R3", 4'd2, 8'h10, 16'h0, 16'h0);   // no borrow
    issue("R3", 4'd2, 8'hE0, 16'h0, 16'h0);   // equal, zero
    issue("R6", 4'd0, 8'h33, 16'h0, 16'h0);
    issue("R4", 4'd3, 8'h33, 16'h0, 16'h0);   // equal compare
    issue("R4", 4'd3, 8'h40, 16'h0, 16'h0);   // operand larger
    issue("R4", 4'd3, 8'h01, 16'h0, 16'h0);
  endtask

  task automatic t_logic();
    issue("R6", 4'd0, 8'hFF, 16'h0, 16'h0);
    issue("R2", 4'd1, 8'h01, 16'h0, 16'h0);   // set carry first
    issue("R6", 4'd0, 8'hF0, 16'h0, 16'h0);
    issue("R5", 4'd4, 8'h3C, 16'h0, 16'h0);
    issue("R5", 4'd5, 8'h03, 16'h0, 16'h0);
    issue("R5", 4'd6, 8'h33, 16'h0, 16'h0);   // zero
  endtask

  task automatic t_byte_step();
    issue("R6", 4'd0, 8'h01, 16'h0, 16'h0);
    issue("R3", 4'd2, 8'h02, 16'h0, 16'h0);   // borrow sets carry
    issue("R7", 4'd7, 8'hFF, 16'h0, 16'h0);   // wraps to 0, carry kept
    issue("R7", 4'd8, 8'h00, 16'h0, 16'h0);   // wraps to FF
    issue("R7", 4'd7, 8'h41, 16'h0, 16'h0);
  endtask

  task automatic t_pair();
    issue("R8", 4'd9,  8'h00, 16'hFFFF, 16'h0);
    issue("R8", 4'd10, 8'h00, 16'h0000, 16'h0);
    issue("R8", 4'd9,  8'h00, 16'h12FF, 16'h0);
    issue("R9", 4'd11, 8'h00, 16'hF000, 16'h1001);  // carry out
    issue("R9", 4'd11, 8'h00, 16'h1234, 16'h0101);  // carry clear
  endtask

  task automatic t_idle_unused();
    repeat (3) @(negedge clk);
    chk("R10", "out_valid idle", {15'h0, out_valid}, 16'h0000);
    check_all("R10");
    issue("R11", 4'd12, 8'hAA, 16'h5555, 16'h5555);
    issue("R11", 4'd15, 8'h00, 16'hFFFF, 16'hFFFF);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready", {15'h0, in_ready}, 16'h0001);
    t_move();
    t_add();
    t_sub_cmp();
    t_logic();
    t_byte_step();
    t_pair();
    t_idle_unused();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule